// File: doc/BRIEF.md
# Serial NAND Power-Up Initializer

This block brings a serial NAND flash device into a known state after the chip leaves reset and identifies it, before any other flash traffic is allowed. It drives a separate SPI shift engine through a simple command/response interface. A command is offered with `cmd_valid` and the fields that describe it, and the engine takes it with `cmd_ready`. Later the engine reports the end of the bus transaction with a one-cycle `rsp_done`, which carries any read data.

The fixed sequence runs as follows. The block sends a device reset and waits a timed gap. It sends a second reset and waits a longer gap. It then reads the two-byte identity and compares it against a parameter table of supported devices. On a match it writes the block-protection feature register, with a value chosen by a read-only strap. It then raises `init_ready`. On a mismatch it raises `id_unsupported` and stops. All wait lengths are counted in clock cycles from parameters, so a simulation can shrink them.

Top module: `spinit_powerup`

## Requirements
- R1: While `rst_n` is low and on the cycle it is released, `init_ready`, `id_unsupported`, `cmd_valid` and `dev_id` are all 0. The first command offered after reset is opcode 0xFF with `cmd_addr_en`=0, `cmd_wr_en`=0 and `cmd_rd_bytes`=0.
- R2: An offered command keeps `cmd_valid` high and all its fields unchanged until a cycle with `cmd_ready` high. In the cycle after acceptance `cmd_valid` is low. No new command is offered until `rsp_done` has been seen for the accepted one.
- R3: After `rsp_done` of the first reset, the second 0xFF command (same fields as in R1) is offered no sooner than RST_GAP_CYC and no later than RST_GAP_CYC+2 cycles later.
- R4: After `rsp_done` of the second reset, the identity command is offered no sooner than RST_GAP_CYC+SETTLE_CYC and no later than RST_GAP_CYC+SETTLE_CYC+2 cycles later.
- R5: The identity command is opcode 0x9F with `cmd_addr_en`=1, `cmd_addr`=0x00, `cmd_wr_en`=0 and `cmd_rd_bytes`=2. `dev_id` takes the value of `rsp_data` sampled with that command's `rsp_done`, with the first byte received in bits 15:8.
- R6: A captured identity of 0x2C12 or 0x2C13 leads on to the protection write. Any other value sets `id_unsupported` to 1. After that no command is ever offered, and `init_ready` stays 0 until reset.
- R7: The protection write is opcode 0x1F with `cmd_addr_en`=1, `cmd_addr`=0xA0, `cmd_wr_en`=1 and `cmd_rd_bytes`=0. Its data byte is 0x38 when `ro_strap` is 1 and 0x00 when it is 0.
- R8: `init_ready` is 0 until the protection write's `rsp_done`. It is 1 from the following cycle and stays 1 until reset. `init_ready` and `id_unsupported` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ro_strap | input | 1 | 1 selects the write-protected setting |
| cmd_valid | output | 1 | A command is offered to the shift engine |
| cmd_ready | input | 1 | The shift engine takes the offered command |
| cmd_opcode | output | 8 | Command byte |
| cmd_addr_en | output | 1 | Command has a one-byte address phase |
| cmd_addr | output | 8 | Address byte |
| cmd_wr_en | output | 1 | Command writes one data byte |
| cmd_wdata | output | 8 | Data byte to write |
| cmd_rd_bytes | output | 2 | Number of bytes to read back (0 or 2) |
| rsp_done | input | 1 | One-cycle pulse: accepted command finished |
| rsp_data | input | 16 | Read data, valid with `rsp_done`, first byte high |
| init_ready | output | 1 | Device reset, identified and protection set |
| id_unsupported | output | 1 | Identity not in the supported table |
| dev_id | output | 16 | Captured device identity |

## Verification
The identity path is tried with both supported values and with near misses, each differing from a supported value in one bit (0x2C11, 0xAC12, 0x2C1A). This separates an exact 16-bit compare from one that checks only part of the word. Random identities, forced to a supported value about half the time, are paired with a random strap. This shows that the protection byte follows the strap and not the identity, and that a failed match always blocks any later command. Random acceptance and completion delays from the engine model confirm that commands are held and that the timed gaps are measured from completion, not from acceptance.

// File: rtl/spinit_pkg.sv
// Shared constants and state encoding for the serial NAND power-up initializer.
// Assumes an 8-bit command byte and a 16-bit identity word.
package spinit_pkg;
    localparam int ID_W = 16;

    localparam logic [7:0] OP_DEV_RESET   = 8'hFF;
    localparam logic [7:0] OP_READ_IDENT  = 8'h9F;
    localparam logic [7:0] OP_SET_FEATURE = 8'h1F;
    localparam logic [7:0] FEAT_PROTECT   = 8'hA0;
    localparam logic [7:0] PROT_LOCKED    = 8'h38;
    localparam logic [7:0] PROT_OPEN      = 8'h00;

    typedef enum logic [3:0] {
        ST_START,
        ST_RST_A_ISSUE,
        ST_RST_A_WAIT,
        ST_GAP_A,
        ST_RST_B_ISSUE,
        ST_RST_B_WAIT,
        ST_GAP_B,
        ST_ID_ISSUE,
        ST_ID_WAIT,
        ST_ID_CHECK,
        ST_PROT_ISSUE,
        ST_PROT_WAIT,
        ST_READY,
        ST_BAD
    } seq_state_t;
endpackage

// File: rtl/spinit_gap_timer.sv
// Down-counter for the timed gaps between commands.
// A start pulse loads the length. The count then falls by one per cycle until it
// reaches zero, and `expired` is high while it is zero.
// Assumes start is never pulsed while a count is still running.
module spinit_gap_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] load,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= load;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_NO_RESTART_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> expired); // R3
endmodule

// File: rtl/spinit_id_match.sv
// Compares a captured identity against a parameter table of supported values.
// One comparator per table entry; the result is purely combinational.
module spinit_id_match #(
    parameter int NUM_IDS = 2,
    parameter int IDW     = 16,
    parameter logic [NUM_IDS*IDW-1:0] ID_TABLE = '0
) (
    input  logic [IDW-1:0] id_in,
    output logic           supported
);
    logic [NUM_IDS-1:0] hit;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_cmp
        // One exact comparison against table entry g.
        assign hit[g] = (id_in == ID_TABLE[g*IDW +: IDW]);
    end

    assign supported = |hit;
endmodule

// File: rtl/spinit_powerup.sv
// Serial NAND power-up sequencer.
// It runs reset, gap, reset, long gap, identity read, table match and
// protection write, then raises ready. A failed match stops the sequence.
// Assumes the external shift engine pulses rsp_done once per accepted command,
// and never before it has accepted that command.
module spinit_powerup
    import spinit_pkg::*;
#(
    parameter int RST_GAP_CYC = 62500,
    parameter int SETTLE_CYC  = 250000,
    parameter int NUM_IDS     = 2,
    parameter logic [NUM_IDS*16-1:0] ID_TABLE = {16'h2C13, 16'h2C12}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ro_strap,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [7:0]  cmd_opcode,
    output logic        cmd_addr_en,
    output logic [7:0]  cmd_addr,
    output logic        cmd_wr_en,
    output logic [7:0]  cmd_wdata,
    output logic [1:0]  cmd_rd_bytes,
    input  logic        rsp_done,
    input  logic [15:0] rsp_data,
    output logic        init_ready,
    output logic        id_unsupported,
    output logic [15:0] dev_id
);
    localparam int LONG_GAP = RST_GAP_CYC + SETTLE_CYC;
    localparam int TW       = $clog2(LONG_GAP + 1);

    seq_state_t    state, state_nx;
    logic          gap_start, gap_expired, id_ok;
    logic [TW-1:0] gap_load;

    // Start a gap when either reset command completes; the second gap is the long one.
    assign gap_start = rsp_done && (state == ST_RST_A_WAIT || state == ST_RST_B_WAIT);
    assign gap_load  = (state == ST_RST_A_WAIT) ? TW'(RST_GAP_CYC) : TW'(LONG_GAP);

    spinit_gap_timer #(.TW(TW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .load    (gap_load),
        .expired (gap_expired)
    );

    spinit_id_match #(.NUM_IDS(NUM_IDS), .IDW(ID_W), .ID_TABLE(ID_TABLE)) u_match (
        .id_in     (dev_id),
        .supported (id_ok)
    );

    // Next-state logic for the fixed initialization chain.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START:       state_nx = ST_RST_A_ISSUE;
            ST_RST_A_ISSUE: if (cmd_ready) state_nx = ST_RST_A_WAIT;
            ST_RST_A_WAIT:  if (rsp_done)  state_nx = ST_GAP_A;
            ST_GAP_A:       if (gap_expired) state_nx = ST_RST_B_ISSUE;
            ST_RST_B_ISSUE: if (cmd_ready) state_nx = ST_RST_B_WAIT;
            ST_RST_B_WAIT:  if (rsp_done)  state_nx = ST_GAP_B;
            ST_GAP_B:       if (gap_expired) state_nx = ST_ID_ISSUE;
            ST_ID_ISSUE:    if (cmd_ready) state_nx = ST_ID_WAIT;
            ST_ID_WAIT:     if (rsp_done)  state_nx = ST_ID_CHECK;
            ST_ID_CHECK:    state_nx = id_ok ? ST_PROT_ISSUE : ST_BAD;
            ST_PROT_ISSUE:  if (cmd_ready) state_nx = ST_PROT_WAIT;
            ST_PROT_WAIT:   if (rsp_done)  state_nx = ST_READY;
            ST_READY:       state_nx = ST_READY;
            ST_BAD:         state_nx = ST_BAD;
            default:        state_nx = ST_START;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_START;
        else        state <= state_nx;
    end

    // Capture the identity word when its read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_id <= '0;
        else if (state == ST_ID_WAIT && rsp_done)
            dev_id <= rsp_data;
    end

    // Command fields decoded from the current issue state.
    always_comb begin
        cmd_valid    = 1'b0;
        cmd_opcode   = 8'h00;
        cmd_addr_en  = 1'b0;
        cmd_addr     = 8'h00;
        cmd_wr_en    = 1'b0;
        cmd_wdata    = 8'h00;
        cmd_rd_bytes = 2'd0;
        unique case (state)
            ST_RST_A_ISSUE, ST_RST_B_ISSUE: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OP_DEV_RESET;
            end
            ST_ID_ISSUE: begin
                cmd_valid    = 1'b1;
                cmd_opcode   = OP_READ_IDENT;
                cmd_addr_en  = 1'b1;
                cmd_rd_bytes = 2'd2;
            end
            ST_PROT_ISSUE: begin
                cmd_valid   = 1'b1;
                cmd_opcode  = OP_SET_FEATURE;
                cmd_addr_en = 1'b1;
                cmd_addr    = FEAT_PROTECT;
                cmd_wr_en   = 1'b1;
                cmd_wdata   = ro_strap ? PROT_LOCKED : PROT_OPEN;
            end
            default: ;
        endcase
    end

    assign init_ready     = (state == ST_READY);
    assign id_unsupported = (state == ST_BAD);

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr))); // R2
    AST_DROP_AFTER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid); // R2
    AST_QUIET_DURING_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gap_expired) |-> !cmd_valid); // R3
    AST_STOP_ON_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        id_unsupported |=> (id_unsupported && !cmd_valid)); // R6
    AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |=> (init_ready && $stable(dev_id))); // R8
    AST_READY_XOR_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_ready && id_unsupported)); // R8
    AST_ID_FROM_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID_WAIT && rsp_done) |=> (dev_id == $past(rsp_data))); // R5
endmodule

// File: tb/spinit_powerup_test.sv
// Bench: an engine model with random accept/complete delays, directed and random identities.
module spinit_powerup_test;
    localparam int GAP = 37;
    localparam int SET = 113;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ro_strap = 1'b0;
    logic cmd_ready = 1'b0;
    logic rsp_done = 1'b0;
    logic [15:0] rsp_data = '0;
    logic cmd_valid, cmd_addr_en, cmd_wr_en, init_ready, id_unsupported;
    logic [7:0] cmd_opcode, cmd_addr, cmd_wdata;
    logic [1:0] cmd_rd_bytes;
    logic [15:0] dev_id;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spinit_powerup #(.RST_GAP_CYC(GAP), .SETTLE_CYC(SET)) uut (
        .clk(clk), .rst_n(rst_n), .ro_strap(ro_strap),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr_en(cmd_addr_en), .cmd_addr(cmd_addr), .cmd_wr_en(cmd_wr_en),
        .cmd_wdata(cmd_wdata), .cmd_rd_bytes(cmd_rd_bytes), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .init_ready(init_ready), .id_unsupported(id_unsupported),
        .dev_id(dev_id)
    );

    function automatic bit is_supported(input logic [15:0] id);
        return (id == 16'h2C12) || (id == 16'h2C13);
    endfunction

    function automatic logic [7:0] prot_value(input logic ro);
        return ro ? 8'h38 : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Wait for an offered command; returns the cycles waited.
    task automatic wait_cmd(output int waited);
        waited = 0;
        while (!cmd_valid && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // Serve one offered command: check its fields, accept it after a random delay, then complete it.
    task automatic serve(input string tag, input logic [7:0] op, input logic aen, input logic [7:0] ad,
                         input logic wen, input logic [7:0] wd, input logic [1:0] rb,
                         input logic [15:0] rdata);
        int hold;
        logic [31:0] fields, exp_fields;
        exp_fields = {op, aen, ad, wen, wd, rb, 4'h0};
        fields = {cmd_opcode, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_bytes, 4'h0};
        chk(cmd_valid, {tag, " valid"}, 32'(cmd_valid), 1);
        chk(fields == exp_fields, {tag, " fields"}, fields, exp_fields);
        hold = int'($urandom_range(3, 0));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            fields = {cmd_opcode, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_bytes, 4'h0};
            chk(cmd_valid && fields == exp_fields, "R2 held until taken", fields, exp_fields);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        chk(!cmd_valid, "R2 drop after accept", 32'(cmd_valid), 0);
        hold = int'($urandom_range(4, 0));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!cmd_valid, "R2 no new command before completion", 32'(cmd_valid), 0);
        end
        rsp_data = rdata;
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_data = 16'hxxxx;
    endtask

    // Run one full power-up with the given identity and strap.
    task automatic run_init(input logic [15:0] id, input logic ro);
        int w;
        rst_n = 1'b0;
        ro_strap = ro;
        repeat (3) @(negedge clk);
        chk(!init_ready && !id_unsupported && !cmd_valid && dev_id == 16'h0, "R1 reset state",
            {init_ready, id_unsupported, cmd_valid, dev_id}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!init_ready && !id_unsupported && dev_id == 16'h0, "R1 after release",
            {init_ready, id_unsupported, dev_id}, 0);
        wait_cmd(w);
        serve("R1 first reset", 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0, 16'h0);
        wait_cmd(w);
        chk(w + 1 >= GAP && w + 1 <= GAP + 2, "R3 short gap", w + 1, GAP);
        serve("R3 second reset", 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0, 16'h0);
        wait_cmd(w);
        chk(w + 1 >= GAP + SET && w + 1 <= GAP + SET + 2, "R4 long gap", w + 1, GAP + SET);
        serve("R5 identity read", 8'h9F, 1'b1, 8'h00, 1'b0, 8'h00, 2'd2, id);
        chk(dev_id == id, "R5 captured identity", dev_id, id);
        if (is_supported(id)) begin
            wait_cmd(w);
            chk(w <= 3, "R6 match proceeds", w, 3);
            chk(!init_ready, "R8 not ready before protection", 32'(init_ready), 0);
            serve("R7 protection write", 8'h1F, 1'b1, 8'hA0, 1'b1, prot_value(ro), 2'd0, 16'h0);
            chk(init_ready && !id_unsupported, "R8 ready after write",
                {init_ready, id_unsupported}, 2'b10);
            repeat (10) @(negedge clk);
            chk(init_ready && !cmd_valid && dev_id == id, "R8 ready holds",
                {init_ready, cmd_valid, dev_id}, {2'b10, id});
        end else begin
            repeat (3) @(negedge clk);
            chk(id_unsupported && !init_ready, "R6 unsupported flag",
                {id_unsupported, init_ready}, 2'b10);
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (cmd_valid || init_ready)
                    chk(0, "R6 stopped after mismatch", {cmd_valid, init_ready}, 0);
            end
            chk(id_unsupported && !cmd_valid, "R6 still stopped", {id_unsupported, cmd_valid}, 2'b10);
        end
    endtask

    initial begin
        logic [15:0] rid;
        void'($urandom(32'd20240611));
        @(negedge clk);
        run_init(16'h2C12, 1'b0);
        run_init(16'h2C13, 1'b1);
        run_init(16'h2C11, 1'b0);
        run_init(16'hAC12, 1'b1);
        run_init(16'h2C1A, 1'b0);
        run_init(16'h2C12, 1'b1);
        for (int k = 0; k < 8; k++) begin
            rid = 16'($urandom());
            if ($urandom_range(1, 0) == 1)
                rid = ($urandom_range(1, 0) == 1) ? 16'h2C13 : 16'h2C12;
            run_init(rid, 1'($urandom_range(1, 0)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule